// File: doc/BRIEF.md
# Byte FIFO with Multi-Width Host Access

This block is the data queue between a 32-bit host register port and a serial byte engine. It runs in one of two directions at a time. In transmit, the host pushes 1, 2 or 4 bytes per access and the engine pops single bytes. In receive, the engine pushes single bytes and the host pops 1, 2 or 4 bytes per access. Within a host word, the earliest byte travels in the most significant lane.

The block reports its current byte count and its fixed capacity. It compares the count against two programmable thresholds and raises a high-water flag and a low-water flag. From these it forms a data-request signal that tells the host when to act. Any access that cannot complete is dropped whole and produces a one-cycle error pulse. A synchronous flush empties the queue.

Top module: `lane_byte_fifo`

## Requirements
- R1: After reset, `level` is 0, `xfer_err` is 0, and both `host_rdata` and `eng_rdata` are 0.
- R2: `capacity` always equals the DEPTH parameter (default 8). `level` gives the number of bytes held, zero-extended to 8 bits.
- R3: In transmit (`dir_rx`=0), a host push moves the number of bytes set by the size code: `host_size` 00 is 1 byte, 01 is 2 bytes, 10 is 4 bytes. The first byte comes from `host_wdata[31:24]`, the next from [23:16], and so on. The engine then pops them one per `eng_pop`, in order, into `eng_rdata` on the following cycle.
- R4: In receive (`dir_rx`=1), each `eng_push` queues `eng_wdata`. A host pop of n bytes places the oldest byte in `host_rdata[31:24]` and the following bytes in the lower lanes. Lanes beyond n read 0. The data is valid the cycle after the pop.
- R5: `host_size` 11 (three bytes) is rejected. No byte moves, and `xfer_err` pulses in the next cycle.
- R6: A push that would take the count above capacity is dropped whole. The count is unchanged by it, and `xfer_err` pulses.
- R7: A pop asking for more bytes than are held is dropped. `xfer_err` pulses, and the read data register keeps its previous value.
- R8: `hi_water` is 1 exactly when `level` ≥ `hi_thr`. `lo_water` is 1 exactly when `level` ≤ `lo_thr`. Both follow `level` and the thresholds with no added delay.
- R9: `data_req` equals `lo_water` in transmit and `hi_water` in receive.
- R10: `flush` empties the queue on the next edge. It overrides any access in the same cycle and produces no error pulse.
- R11: Accesses belonging to the other direction (`host_rd` or `eng_push` in transmit; `host_wr` or `eng_pop` in receive) have no effect and raise no error.
- R12: A push and a pop in the same cycle both complete. The push is judged against the count before the pop, so a full queue rejects the push even while a pop happens in that cycle.
- R13: Byte order is kept across any number of pointer wrap-arounds and mixed access sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous empty request |
| dir_rx | input | 1 | 0 = host-to-engine, 1 = engine-to-host |
| host_wr | input | 1 | Host push strobe |
| host_rd | input | 1 | Host pop strobe |
| host_size | input | 2 | Host access size code |
| host_wdata | input | 32 | Host push data, earliest byte in [31:24] |
| host_rdata | output | 32 | Host pop data, registered |
| eng_push | input | 1 | Engine push strobe |
| eng_wdata | input | 8 | Engine push byte |
| eng_pop | input | 1 | Engine pop strobe |
| eng_rdata | output | 8 | Engine pop byte, registered |
| hi_thr | input | THR_W | High watermark threshold |
| lo_thr | input | THR_W | Low watermark threshold |
| level | output | LVL_W | Bytes currently held |
| capacity | output | LVL_W | Fixed capacity in bytes |
| hi_water | output | 1 | Count at or above high threshold |
| lo_water | output | 1 | Count at or below low threshold |
| data_req | output | 1 | Service request toward the host |
| xfer_err | output | 1 | One-cycle pulse for a dropped access |

## Verification
Most internal faults surface at the ports within a cycle or two of the access that causes them. A count that goes wrong appears in `level` on the very next edge. It then shifts the watermark flags and the overflow and underflow decisions, so a dropped or wrongly accepted access shows up as an unexpected `xfer_err`. A read or write pointer that goes wrong, or a lane that is misplaced, keeps `level` correct. It only shows when the byte in question is popped, which can be up to DEPTH pops later. For that reason the bench checks every popped byte against a byte queue model, including long mixed-size runs that wrap the pointers many times.

// File: rtl/lbf_pkg.sv
package lbf_pkg;
  localparam int HOST_LANES = 4;

  typedef enum logic [1:0] {
    SZ_ONE  = 2'b00,
    SZ_TWO  = 2'b01,
    SZ_FOUR = 2'b10,
    SZ_BAD  = 2'b11
  } acc_size_e;

  // number of bytes a host access moves; 0 marks a rejected code
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (acc_size_e'(code))
      SZ_ONE:  return 3'd1;
      SZ_TWO:  return 3'd2;
      SZ_FOUR: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/lbf_ctrl.sv
module lbf_ctrl
  import lbf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             dir_rx,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [1:0]       host_size,
  input  logic             eng_push,
  input  logic             eng_pop,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [2:0]       push_n,
  output logic [2:0]       pop_n,
  output logic [CNT_W-1:0] count,
  output logic             xfer_err
);
  localparam int SUM_W = CNT_W + 1;

  logic [2:0]       host_n;
  logic             push_req;
  logic             pop_req;
  logic             err_d;
  logic [SUM_W-1:0] pushed_lvl;
  logic [SUM_W-1:0] next_lvl;

  always_comb begin
    host_n     = size_bytes(host_size);
    push_req   = dir_rx ? eng_push : host_wr;
    pop_req    = dir_rx ? host_rd : eng_pop;
    push_n     = dir_rx ? 3'd1 : host_n;
    pop_n      = dir_rx ? host_n : 3'd1;
    // push is judged against the count before any same-cycle pop
    pushed_lvl = SUM_W'(count) + SUM_W'(push_n);
    push_ok    = !flush && push_req && (push_n != 3'd0)
                 && (pushed_lvl <= SUM_W'(DEPTH));
    pop_ok     = !flush && pop_req && (pop_n != 3'd0)
                 && (SUM_W'(count) >= SUM_W'(pop_n));
    err_d      = !flush && ((push_req && !push_ok) || (pop_req && !pop_ok));
    next_lvl   = SUM_W'(count)
                 + (push_ok ? SUM_W'(push_n) : '0)
                 - (pop_ok ? SUM_W'(pop_n) : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      count    <= '0;
      xfer_err <= 1'b0;
    end else begin
      count    <= next_lvl[CNT_W-1:0];
      xfer_err <= err_d;
    end
  end
endmodule

// File: rtl/lbf_store.sv
module lbf_store
  import lbf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push_ok,
  input  logic [2:0]                 push_n,
  input  logic [HOST_LANES-1:0][7:0] push_bytes,
  input  logic                       pop_ok,
  input  logic [2:0]                 pop_n,
  output logic [HOST_LANES-1:0][7:0] peek
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] rptr;

  // ring advance by up to HOST_LANES slots; DEPTH >= HOST_LANES so one fold suffices
  function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W-1:0] p,
                                            input logic [2:0] k);
    logic [PTR_W:0] s;
    s = (PTR_W+1)'(p) + (PTR_W+1)'(k);
    if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
    return s[PTR_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    for (int i = 0; i < HOST_LANES; i++) begin
      if (push_ok && (3'(i) < push_n)) mem[wrap(wptr, 3'(i))] <= push_bytes[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push_ok) wptr <= wrap(wptr, push_n);
      if (pop_ok)  rptr <= wrap(rptr, pop_n);
    end
  end

  for (genvar g = 0; g < HOST_LANES; g++) begin : g_peek
    assign peek[g] = mem[wrap(rptr, 3'(g))];
  end
endmodule

// File: rtl/lbf_marks.sv
module lbf_marks #(
  parameter int CNT_W = 4,
  parameter int THR_W = 4
) (
  input  logic [CNT_W-1:0] count,
  input  logic [THR_W-1:0] hi_thr,
  input  logic [THR_W-1:0] lo_thr,
  input  logic             dir_rx,
  output logic             hi_water,
  output logic             lo_water,
  output logic             data_req
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  always_comb begin
    hi_water = CMP_W'(count) >= CMP_W'(hi_thr);
    lo_water = CMP_W'(count) <= CMP_W'(lo_thr);
    // transmit asks for refill when low; receive asks for draining when high
    data_req = dir_rx ? hi_water : lo_water;
  end
endmodule

// File: rtl/lane_byte_fifo.sv
module lane_byte_fifo
  import lbf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int THR_W = 4,
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             dir_rx,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [1:0]       host_size,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic             eng_push,
  input  logic [7:0]       eng_wdata,
  input  logic             eng_pop,
  output logic [7:0]       eng_rdata,
  input  logic [THR_W-1:0] hi_thr,
  input  logic [THR_W-1:0] lo_thr,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] capacity,
  output logic             hi_water,
  output logic             lo_water,
  output logic             data_req,
  output logic             xfer_err
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);

  logic                       push_ok;
  logic                       pop_ok;
  logic [2:0]                 push_n;
  logic [2:0]                 pop_n;
  logic [CNT_W-1:0]           count;
  logic [HOST_LANES-1:0][7:0] push_bytes;
  logic [HOST_LANES-1:0][7:0] peek;
  logic [31:0]                pop_word;

  lbf_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .dir_rx(dir_rx),
    .host_wr(host_wr), .host_rd(host_rd), .host_size(host_size),
    .eng_push(eng_push), .eng_pop(eng_pop),
    .push_ok(push_ok), .pop_ok(pop_ok), .push_n(push_n), .pop_n(pop_n),
    .count(count), .xfer_err(xfer_err)
  );

  // lane 0 of the store is the earliest byte; on the host word it is bits [31:24]
  for (genvar g = 0; g < HOST_LANES; g++) begin : g_lanes
    assign push_bytes[g] = dir_rx ? ((g == 0) ? eng_wdata : 8'h00)
                                  : host_wdata[31-8*g -: 8];
    assign pop_word[31-8*g -: 8] = (3'(g) < pop_n) ? peek[g] : 8'h00;
  end

  lbf_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .push_ok(push_ok), .push_n(push_n), .push_bytes(push_bytes),
    .pop_ok(pop_ok), .pop_n(pop_n), .peek(peek)
  );

  lbf_marks #(.CNT_W(CNT_W), .THR_W(THR_W)) u_marks (
    .count(count), .hi_thr(hi_thr), .lo_thr(lo_thr), .dir_rx(dir_rx),
    .hi_water(hi_water), .lo_water(lo_water), .data_req(data_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      eng_rdata  <= '0;
    end else if (pop_ok) begin
      if (dir_rx) host_rdata <= pop_word;
      else        eng_rdata  <= peek[0];
    end
  end

  assign level    = LVL_W'(count);
  assign capacity = LVL_W'(DEPTH);
endmodule

// File: rtl/lbf_checker.sv
module lbf_checker #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             dir_rx,
  input logic             host_wr,
  input logic             host_rd,
  input logic [1:0]       host_size,
  input logic             eng_push,
  input logic             eng_pop,
  input logic [LVL_W-1:0] level,
  input logic             hi_water,
  input logic             lo_water,
  input logic             data_req,
  input logic             xfer_err
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH)); // R6

  AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (rst)
    (!flush && !dir_rx && host_wr && host_size != 2'b11 && !eng_pop
     && level == LVL_W'(DEPTH)) |=> (xfer_err && level == LVL_W'(DEPTH))); // R6

  AST_EMPTY_POP_DROP: assert property (@(posedge clk) disable iff (rst)
    (!flush && !dir_rx && eng_pop && !host_wr && level == '0)
    |=> (xfer_err && level == '0)); // R7

  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (rst)
    (!flush && !dir_rx && host_wr && host_size == 2'b11 && !eng_pop)
    |=> (xfer_err && $stable(level))); // R5

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (level == '0 && !xfer_err)); // R10

  AST_OTHER_DIR: assert property (@(posedge clk) disable iff (rst)
    (!flush && !dir_rx && !host_wr && !eng_pop && (host_rd || eng_push))
    |=> ($stable(level) && !xfer_err)); // R11

  AST_EMPTY_LOW: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> lo_water); // R8

  AST_DREQ_TX: assert property (@(posedge clk) disable iff (rst)
    !dir_rx |-> (data_req == lo_water)); // R9

  AST_DREQ_RX: assert property (@(posedge clk) disable iff (rst)
    dir_rx |-> (data_req == hi_water)); // R9
endmodule

bind lane_byte_fifo lbf_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_lbf_chk (
  .clk(clk), .rst(rst), .flush(flush), .dir_rx(dir_rx),
  .host_wr(host_wr), .host_rd(host_rd), .host_size(host_size),
  .eng_push(eng_push), .eng_pop(eng_pop), .level(level),
  .hi_water(hi_water), .lo_water(lo_water), .data_req(data_req),
  .xfer_err(xfer_err)
);

// File: tb/test_lane_byte_fifo.sv
`timescale 1ns/1ps
module test_lane_byte_fifo;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 0, dir_rx = 0, host_wr = 0, host_rd = 0, eng_push = 0, eng_pop = 0;
  logic [1:0]  host_size = 0;
  logic [31:0] host_wdata = 0;
  logic [7:0]  eng_wdata = 0;
  logic [3:0]  hi_thr = 4'd6, lo_thr = 4'd2;
  logic [31:0] host_rdata;
  logic [7:0]  eng_rdata, level, capacity;
  logic        hi_water, lo_water, data_req, xfer_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0]  mq[$];
  logic [31:0] exp_hrd = 0;
  logic [7:0]  exp_erd = 0;
  logic [15:0] lf = 16'hACE1;

  always #5 clk = ~clk;

  lane_byte_fifo i_lane_byte_fifo (
    .clk(clk), .rst(rst), .flush(flush), .dir_rx(dir_rx),
    .host_wr(host_wr), .host_rd(host_rd), .host_size(host_size),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop),
    .eng_rdata(eng_rdata), .hi_thr(hi_thr), .lo_thr(lo_thr),
    .level(level), .capacity(capacity), .hi_water(hi_water),
    .lo_water(lo_water), .data_req(data_req), .xfer_err(xfer_err)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 0;
  endfunction

  task automatic chk_flags(input string tag);
    int sz = mq.size();
    logic h = (sz >= int'(hi_thr));
    logic l = (sz <= int'(lo_thr));
    chk({tag, " R8 hi_water"}, hi_water, h);
    chk({tag, " R8 lo_water"}, lo_water, l);
    chk({tag, " R9 data_req"}, data_req, dir_rx ? h : l);
  endtask

  // one clock with the given strobes, then compare every output with the queue model
  task automatic op(input string tag, input bit f, input bit hw, input bit hr,
                    input bit ep, input bit epop, input logic [1:0] sz,
                    input logic [31:0] wd, input logic [7:0] ew);
    int pre = mq.size();
    int n = nbytes(sz);
    bit preq, qreq, pok, qok, err;
    int pn, qn;
    flush = f; host_wr = hw; host_rd = hr; eng_push = ep; eng_pop = epop;
    host_size = sz; host_wdata = wd; eng_wdata = ew;
    @(posedge clk); #1;
    flush = 0; host_wr = 0; host_rd = 0; eng_push = 0; eng_pop = 0;
    err = 0;
    if (f) begin
      mq.delete();
    end else begin
      preq = dir_rx ? ep : hw;   qreq = dir_rx ? hr : epop;
      pn   = dir_rx ? 1 : n;     qn   = dir_rx ? n : 1;
      pok  = preq && pn != 0 && pre + pn <= DEPTH;
      qok  = qreq && qn != 0 && pre >= qn;
      err  = (preq && !pok) || (qreq && !qok);
      if (qok) begin
        if (dir_rx) begin
          exp_hrd = 0;
          for (int i = 0; i < qn; i++) exp_hrd[31-8*i -: 8] = mq.pop_front();
        end else begin
          exp_erd = mq.pop_front();
        end
      end
      if (pok) begin
        if (dir_rx) mq.push_back(ew);
        else for (int i = 0; i < pn; i++) mq.push_back(wd[31-8*i -: 8]);
      end
    end
    chk({tag, " level"}, level, mq.size());
    chk({tag, " xfer_err"}, xfer_err, err);
    chk({tag, " host_rdata"}, host_rdata, exp_hrd);
    chk({tag, " eng_rdata"}, eng_rdata, exp_erd);
    chk_flags(tag);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state, R2 capacity
    chk("R1 level", level, 0);
    chk("R1 xfer_err", xfer_err, 0);
    chk("R1 host_rdata", host_rdata, 0);
    chk("R1 eng_rdata", eng_rdata, 0);
    chk("R2 capacity", capacity, DEPTH);

    // R3/R5/R6/R7: every size code repeatedly into transmit, then drain past empty
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++)
        op("R3/R5/R6 tx push", 0, 1, 0, 0, 0, 2'(c), 32'h10203040 + 32'(c*16 + r), 8'h0);
      for (int r = 0; r < DEPTH + 1; r++)
        op("R3/R7 tx pop", 0, 0, 0, 0, 1, 2'd0, 32'h0, 8'h0);
    end

    // R8/R9 sweep: every level against every threshold pair, both directions
    for (int lv = 0; lv <= DEPTH; lv++) begin
      op("R10 flush", 1, 0, 0, 0, 0, 2'd0, 32'h0, 8'h0);
      for (int k = 0; k < lv; k++) op("R3 fill", 0, 1, 0, 0, 0, 2'd0, 32'(k) << 24, 8'h0);
      for (int d = 0; d < 2; d++) begin
        dir_rx = d[0];
        for (int h = 0; h < 16; h++)
          for (int l = 0; l < 16; l++) begin
            hi_thr = 4'(h); lo_thr = 4'(l); #1;
            chk_flags("R8/R9 sweep");
          end
      end
      dir_rx = 0; hi_thr = 4'd6; lo_thr = 4'd2;
    end

    // R10: flush wins over a concurrent push
    op("R10 flush+push", 1, 1, 0, 0, 1, 2'd2, 32'hDEADBEEF, 8'h0);
    // R11: wrong-direction strobes in transmit
    op("R11 load", 0, 1, 0, 0, 0, 2'd1, 32'hA1A20000, 8'h0);
    op("R11 other dir", 0, 0, 1, 1, 0, 2'd2, 32'h0, 8'h77);
    op("R11 drain", 0, 0, 0, 0, 1, 2'd0, 32'h0, 8'h0);
    op("R11 drain", 0, 0, 0, 0, 1, 2'd0, 32'h0, 8'h0);

    // R12: full queue rejects push even with a pop in the same cycle
    op("R12 fill", 0, 1, 0, 0, 0, 2'd2, 32'h01020304, 8'h0);
    op("R12 fill", 0, 1, 0, 0, 0, 2'd2, 32'h05060708, 8'h0);
    op("R12 full push+pop", 0, 1, 0, 0, 1, 2'd0, 32'hEE000000, 8'h0);
    op("R12 push+pop", 0, 1, 0, 0, 1, 2'd0, 32'hEF000000, 8'h0);
    op("R10 clear", 1, 0, 0, 0, 0, 2'd0, 32'h0, 8'h0);

    // R4/R7/R11: receive direction, all sizes, short pops, wrong-direction strobes
    dir_rx = 1;
    for (int k = 0; k < 7; k++) op("R4 eng push", 0, 0, 0, 1, 0, 2'd0, 32'h0, 8'hC0 + 8'(k));
    op("R11 rx other dir", 0, 1, 0, 0, 1, 2'd2, 32'h12345678, 8'h0);
    op("R4 pop4", 0, 0, 1, 0, 0, 2'd2, 32'h0, 8'h0);
    op("R7 pop4 short", 0, 0, 1, 0, 0, 2'd2, 32'h0, 8'h0);
    op("R5 rx bad size", 0, 0, 1, 0, 0, 2'd3, 32'h0, 8'h0);
    op("R4 pop2", 0, 0, 1, 0, 0, 2'd1, 32'h0, 8'h0);
    op("R4 pop1", 0, 0, 1, 0, 0, 2'd0, 32'h0, 8'h0);
    op("R7 rx empty pop", 0, 0, 1, 0, 0, 2'd0, 32'h0, 8'h0);
    for (int k = 0; k < DEPTH + 1; k++) op("R6 rx overfill", 0, 0, 0, 1, 0, 2'd0, 32'h0, 8'h50 + 8'(k));
    op("R12 rx full push+pop", 0, 0, 1, 1, 0, 2'd1, 32'h0, 8'h99);

    // R13: long mixed soak in both directions, wrapping the ring many times
    for (int d = 0; d < 2; d++) begin
      dir_rx = d[0];
      op("R10 soak clear", 1, 0, 0, 0, 0, 2'd0, 32'h0, 8'h0);
      for (int it = 0; it < 800; it++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        op("R13 soak", 0, lf[0], lf[1], lf[2], lf[3], lf[5:4],
           {lf, lf ^ 16'h5A5A}, lf[15:8]);
      end
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule